// File: doc/BRIEF.md
# Register-Amount Shifter Operand Unit

This block forms the second operand of a 32-bit data-processing datapath when the shift distance is held in a register. It performs logical left and logical right shifts, and it also produces the shifter carry-out that the flag logic may later use. It reads the register indices and the shift kind from the low twelve bits of the instruction word. It adds the program-counter read-ahead to any source that is the program counter. It uses only the low byte of the amount register, so distances of 0 to 255 are possible. Zero, exactly the word width, and anything beyond the word width each follow their own result and carry rule.

A register-specified shift costs the pipeline one extra cycle. The unit raises `extra_cycle` during the cycle in which `start` is high. It then registers the outcome and presents `result`, `carry_out` and `unsupported` in the next cycle, together with `out_valid`. The outputs hold their values until the next `start`. Shift kinds other than the two logical ones are not handled here. They are reported through `unsupported` and give a zero result and a zero carry.

Top module: `regshift_operand`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `result`, `carry_out` and `unsupported` all become 0.
- R2: `extra_cycle` is high exactly in the cycles where `start` is high. `out_valid` is high in the cycle after each `start`, and low otherwise.
- R3: The shift distance is `amount_reg[7:0]`. Bits 31:8 of the amount register have no effect on the outputs.
- R4: When `instr[3:0]` equals 15, meaning the value source is the program counter, the operand used is `value + 4`.
- R5: When `instr[11:8]` equals 15, meaning the amount source is the program counter, the distance is `(amount_reg + 4)` masked to 8 bits.
- R6: A distance of 0 passes the operand through unchanged, and `carry_out` equals `carry_in`. This holds for both kinds.
- R7: With kind `instr[6:5]`=00 (logical left) and a distance d in 1..31, `result` is the operand shifted left by d, and `carry_out` is operand bit 32−d.
- R8: With kind 01 (logical right) and a distance d in 1..31, `result` is the operand shifted right by d with zero fill, and `carry_out` is operand bit d−1.
- R9: A distance of exactly 32 gives `result` 0. `carry_out` is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R10: A distance above 32 gives `result` 0 and `carry_out` 0.
- R11: Kinds 10 and 11 set `unsupported` to 1 and give `result` 0 and `carry_out` 0. Kinds 00 and 01 clear `unsupported`.
- R12: In a cycle without `start`, the registered outputs `result`, `carry_out` and `unsupported` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue a shift this cycle |
| instr | input | 12 | [3:0] value index, [6:5] shift kind, [11:8] amount index |
| value | input | 32 | Value register read data |
| amount_reg | input | 32 | Amount register read data |
| carry_in | input | 1 | Current carry flag |
| extra_cycle | output | 1 | Request for one extra cycle |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |
| unsupported | output | 1 | Shift kind not handled |

## Verification
The clocked properties tie an output cycle to the inputs present one cycle earlier. They therefore assume that `instr`, `value`, `amount_reg` and `carry_in` are stable and meaningful in every cycle where `start` is high. The amount and carry properties also assume that the amount index is not the program counter, because they read the raw low byte directly. The bench drives every input half a cycle before the sampling edge and drops `start` after one edge. It uses ordinary register indices, except in the test aimed at the program-counter adjustment. The distance set covers 0, 1, 31, 32, 33 and 255 in both directions, with the incoming carry at both values.

// File: rtl/regshift_pkg.sv
// Package: shared encodings for the register-amount shifter operand unit.
// Assumes instruction fields sit at fixed positions decoded by the issue stage.
package regshift_pkg;
    typedef enum logic [1:0] {
        KIND_LSL  = 2'b00,
        KIND_LSR  = 2'b01,
        KIND_RES2 = 2'b10,
        KIND_RES3 = 2'b11
    } shift_kind_e;

    localparam int INSTR_W     = 12;
    localparam int VAL_IDX_LO  = 0;
    localparam int KIND_LO     = 5;
    localparam int AMT_IDX_LO  = 8;
endpackage

// File: rtl/regshift_fetch.sv
// Module: regshift_fetch
// Applies the program-counter read-ahead to either source and masks the
// amount register down to the shift distance. Purely combinational.
// Assumes the caller supplies the normal register read values.
module regshift_fetch #(
    parameter int DATA_W   = 32,
    parameter int AMT_W    = 8,
    parameter int IDX_W    = 4,
    parameter int PC_IDX   = 15,
    parameter int PC_BONUS = 4
) (
    input  logic [IDX_W-1:0]  val_idx,
    input  logic [IDX_W-1:0]  amt_idx,
    input  logic [DATA_W-1:0] val_raw,
    input  logic [DATA_W-1:0] amt_raw,
    output logic [DATA_W-1:0] val_eff,
    output logic [AMT_W-1:0]  amt_eff
);
    localparam logic [IDX_W-1:0]  PC_CODE = IDX_W'(PC_IDX);
    localparam logic [DATA_W-1:0] BONUS   = DATA_W'(PC_BONUS);

    logic [DATA_W-1:0] amt_full;

    // Add read-ahead where a source is the program counter, then mask the distance.
    always_comb begin
        val_eff  = (val_idx == PC_CODE) ? val_raw + BONUS : val_raw;
        amt_full = (amt_idx == PC_CODE) ? amt_raw + BONUS : amt_raw;
        amt_eff  = amt_full[AMT_W-1:0];
    end
endmodule

// File: rtl/regshift_core.sv
// Module: regshift_core
// Combinational logical shifter with carry-out for register distances.
// Handles zero, in-range, exactly-width and beyond-width distances.
// Assumes DATA_W fits in AMT_W bits.
module regshift_core
    import regshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  shift_kind_e       kind,
    input  logic [DATA_W-1:0] val,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              bad_kind
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    logic [DATA_W:0] left_ext;
    logic [DATA_W:0] right_ext;

    // Widened shifts: the extra bit catches the last bit shifted out.
    always_comb begin
        left_ext  = {1'b0, val} << amt;
        right_ext = {val, 1'b0} >> amt;
    end

    // Select result and carry by kind and distance class.
    always_comb begin
        bad_kind = (kind != KIND_LSL) && (kind != KIND_LSR);
        res      = '0;
        cout     = 1'b0;
        if (bad_kind) begin
            res  = '0;
            cout = 1'b0;
        end else if (amt == '0) begin
            res  = val;
            cout = cin;
        end else if (amt > FULL) begin
            res  = '0;
            cout = 1'b0;
        end else if (kind == KIND_LSL) begin
            res  = left_ext[DATA_W-1:0];
            cout = left_ext[DATA_W];
        end else begin
            res  = right_ext[DATA_W:1];
            cout = right_ext[0];
        end
    end
endmodule

// File: rtl/regshift_operand.sv
// Module: regshift_operand (top)
// Register-amount shifter operand stage: requests one extra cycle when a
// shift is issued and presents the registered operand and carry one cycle later.
// Assumes inputs are stable while start is high.
module regshift_operand
    import regshift_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_W    = 8,
    parameter int IDX_W    = 4,
    parameter int PC_IDX   = 15,
    parameter int PC_BONUS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   value,
    input  logic [DATA_W-1:0]   amount_reg,
    input  logic                carry_in,
    output logic                extra_cycle,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                carry_out,
    output logic                unsupported
);
    logic [IDX_W-1:0]  val_idx;
    logic [IDX_W-1:0]  amt_idx;
    shift_kind_e       kind;
    logic [DATA_W-1:0] val_eff;
    logic [AMT_W-1:0]  amt_eff;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic              sh_bad;

    // Split the instruction into its three fields.
    always_comb begin
        val_idx = instr[VAL_IDX_LO +: IDX_W];
        amt_idx = instr[AMT_IDX_LO +: IDX_W];
        kind    = shift_kind_e'(instr[KIND_LO +: 2]);
    end

    regshift_fetch #(
        .DATA_W(DATA_W), .AMT_W(AMT_W), .IDX_W(IDX_W),
        .PC_IDX(PC_IDX), .PC_BONUS(PC_BONUS)
    ) u_fetch (
        .val_idx (val_idx),
        .amt_idx (amt_idx),
        .val_raw (value),
        .amt_raw (amount_reg),
        .val_eff (val_eff),
        .amt_eff (amt_eff)
    );

    regshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .kind     (kind),
        .val      (val_eff),
        .amt      (amt_eff),
        .cin      (carry_in),
        .res      (sh_res),
        .cout     (sh_cout),
        .bad_kind (sh_bad)
    );

    // Extra-cycle request accompanies every issued shift.
    always_comb extra_cycle = start;

    // Capture the shift outcome on issue; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            carry_out   <= 1'b0;
            unsupported <= 1'b0;
        end else begin
            out_valid <= start;
            if (start) begin
                result      <= sh_res;
                carry_out   <= sh_cout;
                unsupported <= sh_bad;
            end
        end
    end
endmodule

// File: rtl/regshift_operand_chk.sv
// Module: regshift_operand_chk
// Checker for regshift_operand, bound to every instance of the top.
// Assumes inputs are stable in start cycles and the amount index is not 15
// for the amount-dependent properties.
module regshift_operand_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [11:0] instr,
    input logic [31:0] amount_reg,
    input logic        carry_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        carry_out,
    input logic        unsupported
);
    logic plain_amt;
    logic known_kind;

    // Qualifiers for the amount-dependent properties.
    always_comb begin
        plain_amt  = (instr[11:8] != 4'd15);
        known_kind = (instr[6] == 1'b0);
    end

    a_r2_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);

    a_r2_valid_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(start));

    a_r6_zero_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && plain_amt && known_kind && amount_reg[7:0] == 8'd0)
        |=> (carry_out == $past(carry_in)));

    a_r10_beyond_width: assert property (@(posedge clk) disable iff (!rst_n)
        (start && plain_amt && known_kind && amount_reg[7:0] > 8'd32)
        |=> (result == 32'd0 && !carry_out));

    a_r11_bad_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (start && instr[6]) |=> (unsupported && result == 32'd0 && !carry_out));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(carry_out) && $stable(unsupported)));
endmodule

bind regshift_operand regshift_operand_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .instr       (instr),
    .amount_reg  (amount_reg),
    .carry_in    (carry_in),
    .out_valid   (out_valid),
    .result      (result),
    .carry_out   (carry_out),
    .unsupported (unsupported)
);

// File: tb/test_regshift_operand.sv
`timescale 1ns/1ps
// Directed bench for regshift_operand: one task per scenario.
module test_regshift_operand;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [31:0] value = '0;
    logic [31:0] amount_reg = '0;
    logic        carry_in = 1'b0;
    logic        extra_cycle;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;
    logic        unsupported;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regshift_operand i_regshift_operand (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .value(value), .amount_reg(amount_reg), .carry_in(carry_in),
        .extra_cycle(extra_cycle), .out_valid(out_valid), .result(result),
        .carry_out(carry_out), .unsupported(unsupported)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: follows the requirement text only.
    task automatic model(input logic [1:0] kind, input logic [31:0] v, input int d,
                         input logic c, output logic [31:0] r, output logic co);
        if (kind[1]) begin r = 0; co = 0; end
        else if (d == 0) begin r = v; co = c; end
        else if (d < 32) begin
            if (kind == 2'b00) begin r = v << d; co = v[32-d]; end
            else begin r = v >> d; co = v[d-1]; end
        end else if (d == 32) begin
            r = 0; co = (kind == 2'b00) ? v[0] : v[31];
        end else begin r = 0; co = 0; end
    endtask

    function automatic logic [11:0] mk(input int vi, input logic [1:0] k, input int ai);
        return {4'(ai), 1'b0, k, 1'b0, 4'(vi)};
    endfunction

    // Issue one shift; check the request and the registered outcome.
    task automatic issue(input string req, input logic [11:0] ins, input logic [31:0] v,
                         input logic [31:0] a, input logic c,
                         input logic [31:0] er, input logic ec, input logic eu);
        @(negedge clk);
        instr = ins; value = v; amount_reg = a; carry_in = c; start = 1'b1;
        #1;
        check({req, "/R2 extra_cycle"}, 32'(extra_cycle), 32'd1);
        @(negedge clk);
        start = 1'b0;
        check({req, "/R2 out_valid"}, 32'(out_valid), 32'd1);
        check({req, " result"}, result, er);
        check({req, " carry"}, 32'(carry_out), 32'(ec));
        check({req, " unsupported"}, 32'(unsupported), 32'(eu));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 result", result, 0);
        check("R1 carry", 32'(carry_out), 0);
        check("R1 unsupported", 32'(unsupported), 0);
        check("R2 no request", 32'(extra_cycle), 0);
        rst_n = 1'b1;
    endtask

    // R6 R7 R8 R9 R10: distance sweep, both kinds, both carries.
    task automatic t_sweep();
        int dl[6] = '{0, 1, 31, 32, 33, 255};
        logic [31:0] pat[2] = '{32'h8000_0001, 32'h7FFF_FFFE};
        logic [31:0] r;
        logic co;
        foreach (dl[i]) for (int k = 0; k < 2; k++) for (int c = 0; c < 2; c++)
            for (int p = 0; p < 2; p++) begin
                model(2'(k), pat[p], dl[i], c[0], r, co);
                issue($sformatf("R6-10 d=%0d k=%0d", dl[i], k), mk(2, 2'(k), 5),
                      pat[p], 32'(dl[i]), c[0], r, co, 1'b0);
            end
    endtask

    task automatic t_upper_bits();
        logic [31:0] r;
        logic co;
        model(2'b00, 32'h0000_00F3, 4, 1'b0, r, co);
        issue("R3 upper ignored", mk(1, 2'b00, 3), 32'h0000_00F3, 32'hABCD_1204, 1'b0, r, co, 1'b0);
        model(2'b01, 32'hC000_0000, 0, 1'b1, r, co);
        issue("R3 masked zero", mk(1, 2'b01, 3), 32'hC000_0000, 32'hFFFF_FF00, 1'b1, r, co, 1'b0);
    endtask

    task automatic t_pc();
        logic [31:0] r;
        logic co;
        model(2'b01, 32'h0000_1000 + 4, 2, 1'b0, r, co);
        issue("R4 value is pc", mk(15, 2'b01, 3), 32'h0000_1000, 32'd2, 1'b0, r, co, 1'b0);
        model(2'b00, 32'h0000_0003, 3, 1'b0, r, co);
        issue("R5 amount is pc", mk(1, 2'b00, 15), 32'h0000_0003, 32'hFFFF_FFFF, 1'b0, r, co, 1'b0);
    endtask

    task automatic t_unsupported();
        issue("R11 kind 10", mk(1, 2'b10, 3), 32'hFFFF_FFFF, 32'd4, 1'b1, 0, 1'b0, 1'b1);
        issue("R11 kind 11", mk(1, 2'b11, 3), 32'h1234_5678, 32'd0, 1'b1, 0, 1'b0, 1'b1);
        issue("R11 cleared", mk(1, 2'b00, 3), 32'h0000_0001, 32'd1, 1'b0, 32'd2, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        issue("R12 setup", mk(1, 2'b00, 3), 32'h8000_0000, 32'd1, 1'b0, 0, 1'b1, 1'b0);
        @(negedge clk);
        instr = mk(1, 2'b10, 3); value = 32'h5555_5555; amount_reg = 0; carry_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 result held", result, 0);
        check("R12 carry held", 32'(carry_out), 1);
        check("R12 unsupported held", 32'(unsupported), 0);
        check("R2 valid low", 32'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_upper_bits();
        t_pc();
        t_unsupported();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule